// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller of a 10-bit successive-approximation converter. A small configuration port selects one of six input channels and a reference choice while the converter is idle. A one-cycle start pulse then opens a fixed frame of thirteen converter-clock cycles. The first two cycles drive the sample-hold into tracking and let the reference and input mux settle. Ten decision cycles follow, one result bit per cycle from the most significant bit down. A final cycle moves the finished code into two byte-wide result registers and raises a completion flag that software polls.

The analog parts (comparator, DAC, mux, sample-hold) are outside the block. The sequencer presents a trial code to the DAC and reads back one comparator bit. That bit is 1 when the held input is at or above the trial level.

Top module: `adc_sar_sequencer`

## Requirements
- R1: After reset, `busy`, `done` and `sh_track` are 0, both result registers read 0, `mux_sel` is 0 and `ref_int_sel` is 0.
- R2: A `start` pulse sampled while idle makes `busy` high for exactly 13 cycles. `busy` falls on the 13th rising edge after the one that sampled `start`.
- R3: `sh_track` is high for the first two cycles of the frame and low for the rest of the frame.
- R4: In the k-th decision cycle (k = 0..9), `trial_code` bit 9-k is 1. The bits above it hold the bits already decided, and the bits below it are 0.
- R5: In each decision cycle, the trial bit is kept when `cmp_above` is 1 and cleared when it is 0. The final code is therefore the largest code not above the input level: a zero input gives 0, and an input at or beyond full scale gives 0x3FF.
- R6: `res_lo` carries code bits 7..0. Bits 1..0 of `res_hi` carry code bits 9..8, and bits 7..2 of `res_hi` are always 0.
- R7: `done` rises on the same edge at which `busy` falls and the result loads. It stays high while idle and clears on the edge that accepts the next start.
- R8: A `start` that arrives while `busy` is high is ignored. The running frame neither restarts nor lengthens.
- R9: While idle, a `cfg_wr` with a channel 0..5 updates `mux_sel` and `ref_int_sel` on the next edge. A write with channel 6 or 7, or any write while busy, leaves both outputs unchanged.
- R10: The result registers keep their value through a conversion and change only at its load edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_chan | input | 3 | Channel number to write |
| cfg_ref | input | 1 | Reference choice to write (1 = internal 1.1 V full scale) |
| start | input | 1 | Start-conversion pulse |
| cmp_above | input | 1 | Comparator: input at or above the trial level |
| busy | output | 1 | A conversion frame is running |
| sh_track | output | 1 | Sample-hold tracking control |
| mux_sel | output | 3 | Selected input channel |
| ref_int_sel | output | 1 | Reference choice control |
| trial_code | output | 10 | Code presented to the DAC |
| res_lo | output | 8 | Result bits 7..0 |
| res_hi | output | 8 | Result bits 9..8 in bits 1..0, zero above |
| done | output | 1 | End-of-conversion flag |

## Verification
The hardest case to reach from the ports is a start pulse or configuration write that lands in the middle of a running frame. The risk there is that a restart or a channel change corrupts the search without showing up in the result. The bench places a spurious start and a channel write inside the decision phase of a conversion. It then checks that the frame still ends on cycle 13, that the channel is unchanged and that the code matches the level. Conversions at zero, at full scale, beyond full scale, and at alternating-bit levels exercise every keep/clear decision path.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int ADC_CODE_W   = 10;
  localparam int ADC_BYTE_W   = 8;
  localparam int ADC_NUM_CH   = 6;
  localparam int ADC_INIT_CYC = 2;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_INIT = 2'd1,
    SEQ_BIT  = 2'd2,
    SEQ_LOAD = 2'd3
  } seq_state_t;
endpackage

// File: rtl/adc_seq_cfg.sv
module adc_seq_cfg #(
  parameter int NUM_CH = adc_seq_pkg::ADC_NUM_CH,
  parameter int CH_W   = $clog2(NUM_CH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            busy,
  input  logic            cfg_wr,
  input  logic [CH_W-1:0] cfg_chan,
  input  logic            cfg_ref,
  output logic [CH_W-1:0] chan_q,
  output logic            ref_q
);
  localparam logic [CH_W-1:0] CH_LAST = CH_W'(NUM_CH - 1);

  function automatic logic chan_ok(input logic [CH_W-1:0] c);
    chan_ok = (c <= CH_LAST);
  endfunction

  logic wr_take;
  assign wr_take = cfg_wr && !busy && chan_ok(cfg_chan);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q <= '0;
      ref_q  <= 1'b0;
    end else if (wr_take) begin
      chan_q <= cfg_chan;
      ref_q  <= cfg_ref;
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int CODE_W   = adc_seq_pkg::ADC_CODE_W,
  parameter int INIT_CYC = adc_seq_pkg::ADC_INIT_CYC,
  parameter int MAXC     = (CODE_W > INIT_CYC) ? CODE_W : INIT_CYC,
  parameter int CNT_W    = $clog2(MAXC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic             start_acc,
  output logic             sh_track,
  output logic             bit_cyc,
  output logic [CNT_W-1:0] bit_idx,
  output logic             load_cyc
);
  import adc_seq_pkg::*;

  localparam logic [CNT_W-1:0] INIT_LAST = CNT_W'(INIT_CYC - 1);
  localparam logic [CNT_W-1:0] BIT_LAST  = CNT_W'(CODE_W - 1);

  seq_state_t st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign busy      = (st_q != SEQ_IDLE);
  assign start_acc = (st_q == SEQ_IDLE) && start;
  assign sh_track  = (st_q == SEQ_INIT);
  assign bit_cyc   = (st_q == SEQ_BIT);
  assign load_cyc  = (st_q == SEQ_LOAD);
  assign bit_idx   = BIT_LAST - cnt_q;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      SEQ_IDLE: begin
        if (start) begin
          st_d  = SEQ_INIT;
          cnt_d = '0;
        end
      end
      SEQ_INIT: begin
        if (cnt_q == INIT_LAST) begin
          st_d  = SEQ_BIT;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      SEQ_BIT: begin
        if (cnt_q == BIT_LAST) begin
          st_d  = SEQ_LOAD;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      SEQ_LOAD: begin
        st_d = SEQ_IDLE;
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SEQ_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/adc_seq_sar.sv
module adc_seq_sar #(
  parameter int CODE_W = adc_seq_pkg::ADC_CODE_W,
  parameter int IDX_W  = $clog2(CODE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_acc,
  input  logic              bit_cyc,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic              cmp_above,
  output logic [CODE_W-1:0] trial_code,
  output logic [CODE_W-1:0] code
);
  logic [CODE_W-1:0] sel_mask;
  logic [CODE_W-1:0] code_d;

  for (genvar i = 0; i < CODE_W; i++) begin : g_bit
    assign sel_mask[i] = bit_cyc && (bit_idx == IDX_W'(i));
    assign code_d[i]   = sel_mask[i] ? cmp_above : code[i];
  end

  assign trial_code = code | sel_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code <= '0;
    end else if (start_acc) begin
      code <= '0;
    end else begin
      code <= code_d;
    end
  end
endmodule

// File: rtl/adc_seq_result.sv
module adc_seq_result #(
  parameter int CODE_W = adc_seq_pkg::ADC_CODE_W,
  parameter int BYTE_W = adc_seq_pkg::ADC_BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_acc,
  input  logic              load_cyc,
  input  logic [CODE_W-1:0] code,
  output logic [BYTE_W-1:0] res_lo,
  output logic [BYTE_W-1:0] res_hi,
  output logic              done
);
  function automatic logic [BYTE_W-1:0] lo_of(input logic [CODE_W-1:0] c);
    lo_of = c[BYTE_W-1:0];
  endfunction

  function automatic logic [BYTE_W-1:0] hi_of(input logic [CODE_W-1:0] c);
    hi_of = BYTE_W'(c >> BYTE_W);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_lo <= '0;
      res_hi <= '0;
    end else if (load_cyc) begin
      res_lo <= lo_of(code);
      res_hi <= hi_of(code);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0;
    end else if (load_cyc) begin
      done <= 1'b1;
    end else if (start_acc) begin
      done <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_sar_sequencer.sv
module adc_sar_sequencer #(
  parameter int CODE_W   = adc_seq_pkg::ADC_CODE_W,
  parameter int BYTE_W   = adc_seq_pkg::ADC_BYTE_W,
  parameter int NUM_CH   = adc_seq_pkg::ADC_NUM_CH,
  parameter int INIT_CYC = adc_seq_pkg::ADC_INIT_CYC,
  parameter int CH_W     = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [CH_W-1:0]   cfg_chan,
  input  logic              cfg_ref,
  input  logic              start,
  input  logic              cmp_above,
  output logic              busy,
  output logic              sh_track,
  output logic [CH_W-1:0]   mux_sel,
  output logic              ref_int_sel,
  output logic [CODE_W-1:0] trial_code,
  output logic [BYTE_W-1:0] res_lo,
  output logic [BYTE_W-1:0] res_hi,
  output logic              done
);
  localparam int MAXC  = (CODE_W > INIT_CYC) ? CODE_W : INIT_CYC;
  localparam int IDX_W = $clog2(MAXC);

  // named internal events, observed by the bound checker
  logic              start_acc;
  logic              bit_cyc;
  logic [IDX_W-1:0]  bit_idx;
  logic              load_cyc;
  logic [CODE_W-1:0] code;

  adc_seq_cfg #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .cfg_wr   (cfg_wr),
    .cfg_chan (cfg_chan),
    .cfg_ref  (cfg_ref),
    .chan_q   (mux_sel),
    .ref_q    (ref_int_sel)
  );

  adc_seq_ctrl #(.CODE_W(CODE_W), .INIT_CYC(INIT_CYC), .MAXC(MAXC), .CNT_W(IDX_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .start_acc (start_acc),
    .sh_track  (sh_track),
    .bit_cyc   (bit_cyc),
    .bit_idx   (bit_idx),
    .load_cyc  (load_cyc)
  );

  adc_seq_sar #(.CODE_W(CODE_W), .IDX_W(IDX_W)) u_sar (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_acc  (start_acc),
    .bit_cyc    (bit_cyc),
    .bit_idx    (bit_idx),
    .cmp_above  (cmp_above),
    .trial_code (trial_code),
    .code       (code)
  );

  adc_seq_result #(.CODE_W(CODE_W), .BYTE_W(BYTE_W)) u_res (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_acc (start_acc),
    .load_cyc  (load_cyc),
    .code      (code),
    .res_lo    (res_lo),
    .res_hi    (res_hi),
    .done      (done)
  );
endmodule

// File: rtl/adc_sar_sequencer_chk.sv
module adc_sar_sequencer_chk #(
  parameter int CODE_W   = 10,
  parameter int BYTE_W   = 8,
  parameter int NUM_CH   = 6,
  parameter int INIT_CYC = 2,
  parameter int CH_W     = 3,
  parameter int IDX_W    = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              sh_track,
  input logic [CH_W-1:0]   mux_sel,
  input logic              ref_int_sel,
  input logic [CODE_W-1:0] trial_code,
  input logic [BYTE_W-1:0] res_lo,
  input logic [BYTE_W-1:0] res_hi,
  input logic              done,
  input logic              start_acc,
  input logic              bit_cyc,
  input logic [IDX_W-1:0]  bit_idx,
  input logic              load_cyc
);
  localparam int FRAME = INIT_CYC + CODE_W + 1;
  localparam int FC_W  = $clog2(FRAME + 1);
  localparam logic [CH_W-1:0] CH_LAST = CH_W'(NUM_CH - 1);

  logic [FC_W-1:0] frame_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     frame_cnt <= '0;
    else if (!busy) frame_cnt <= '0;
    else            frame_cnt <= frame_cnt + 1'b1;
  end

  a_r2_frame_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (frame_cnt == FC_W'(FRAME)));

  a_r3_track_first: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> sh_track);

  a_r3_track_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sh_track) |-> (bit_cyc && bit_idx == IDX_W'(CODE_W - 1)));

  a_r4_trial_bit: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cyc |-> trial_code[bit_idx]);

  a_r6_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
    res_hi[BYTE_W-1:CODE_W-BYTE_W] == '0);

  a_r7_done_with_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $fell(busy));

  a_r7_done_clear: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> !done);

  a_r9_chan_range: assert property (@(posedge clk) disable iff (!rst_n)
    mux_sel <= CH_LAST);

  a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(mux_sel) && $stable(ref_int_sel)));

  a_r10_res_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load_cyc |=> ($stable(res_lo) && $stable(res_hi)));
endmodule

bind adc_sar_sequencer adc_sar_sequencer_chk #(
  .CODE_W(CODE_W), .BYTE_W(BYTE_W), .NUM_CH(NUM_CH),
  .INIT_CYC(INIT_CYC), .CH_W(CH_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .sh_track(sh_track),
  .mux_sel(mux_sel), .ref_int_sel(ref_int_sel), .trial_code(trial_code),
  .res_lo(res_lo), .res_hi(res_hi), .done(done), .start_acc(start_acc),
  .bit_cyc(bit_cyc), .bit_idx(bit_idx), .load_cyc(load_cyc)
);

// File: tb/adc_sar_sequencer_tb.sv
module adc_sar_sequencer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [2:0] cfg_chan = 3'd0;
  logic       cfg_ref = 1'b0;
  logic       start = 1'b0;
  logic       cmp_above;
  logic       busy, sh_track, ref_int_sel, done;
  logic [2:0] mux_sel;
  logic [9:0] trial_code;
  logic [7:0] res_lo, res_hi;

  int level = 0;
  int n_checks = 0;
  int n_errors = 0;
  int last_code = 0;
  int exp_q[$];

  always #2.5 clk = ~clk;

  // comparator stand-in: input at or above the trial level
  assign cmp_above = (level >= int'(trial_code));

  adc_sar_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_chan(cfg_chan),
    .cfg_ref(cfg_ref), .start(start), .cmp_above(cmp_above), .busy(busy),
    .sh_track(sh_track), .mux_sel(mux_sel), .ref_int_sel(ref_int_sel),
    .trial_code(trial_code), .res_lo(res_lo), .res_hi(res_hi), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int expect_code(input int lvl);
    if (lvl <= 0) return 0;
    if (lvl >= 1023) return 1023;
    return lvl;
  endfunction

  // monitor: scoreboard pop on each rising done
  logic done_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && done && !done_prev) begin
      int e;
      if (exp_q.size() == 0) begin
        check(1'b0, "R5 unexpected result", {res_hi, res_lo}, -1);
      end else begin
        e = exp_q.pop_front();
        check(int'(res_lo) == (e % 256), "R5/R6 low byte", res_lo, e % 256);
        check(int'(res_hi) == (e / 256), "R5/R6 high byte", res_hi, e / 256);
        last_code = e;
      end
    end
    done_prev <= done;
  end

  // driver: one conversion, optionally disturbed mid-frame
  task automatic convert(input int lvl, input bit disturb);
    int chan_before;
    chan_before = int'(mux_sel);
    @(negedge clk);
    level = lvl;
    start = 1'b1;
    exp_q.push_back(expect_code(lvl));
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R2 busy after start", busy, 1);
    check(done == 1'b0, "R7 done cleared at start", done, 0);
    check(sh_track == 1'b1, "R3 track cycle 1", sh_track, 1);
    check(int'({res_hi, res_lo}) == last_code, "R10 result held", {res_hi, res_lo}, last_code);
    @(negedge clk);
    check(sh_track == 1'b1, "R3 track cycle 2", sh_track, 1);
    for (int j = 0; j < 10; j++) begin
      @(negedge clk);
      if (j == 0) check(sh_track == 1'b0, "R3 hold in decisions", sh_track, 0);
      check(trial_code[9-j] == 1'b1, "R4 trial bit set", trial_code, 9 - j);
      check((int'(trial_code) % (1 << (9 - j))) == 0, "R4 lower bits clear",
            trial_code, 0);
      if (disturb && j == 2) begin
        start = 1'b1;
        cfg_wr = 1'b1;
        cfg_chan = 3'd2;
      end
      if (disturb && j == 3) begin
        start = 1'b0;
        cfg_wr = 1'b0;
      end
    end
    @(negedge clk);
    check(busy == 1'b1, "R2 busy in load cycle", busy, 1);
    check(int'({res_hi, res_lo}) == last_code, "R10 held until load",
          {res_hi, res_lo}, last_code);
    @(negedge clk);
    check(busy == 1'b0, "R2/R8 busy ends on cycle 13", busy, 0);
    check(done == 1'b1, "R7 done with result", done, 1);
    if (disturb) check(int'(mux_sel) == chan_before, "R9 write while busy ignored",
                       mux_sel, chan_before);
  endtask

  task automatic cfg_write(input int ch, input bit rf);
    @(negedge clk);
    cfg_wr = 1'b1;
    cfg_chan = 3'(ch);
    cfg_ref = rf;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && done == 1'b0 && sh_track == 1'b0, "R1 control idle",
          {busy, done, sh_track}, 0);
    check(res_lo == 8'd0 && res_hi == 8'd0, "R1 results zero", {res_hi, res_lo}, 0);
    check(mux_sel == 3'd0 && ref_int_sel == 1'b0, "R1 config zero",
          {mux_sel, ref_int_sel}, 0);
    rst_n = 1'b1;

    cfg_write(4, 1'b1);
    check(mux_sel == 3'd4, "R9 channel write", mux_sel, 4);
    check(ref_int_sel == 1'b1, "R9 reference write", ref_int_sel, 1);
    cfg_write(7, 1'b0);
    check(mux_sel == 3'd4, "R9 channel 7 ignored", mux_sel, 4);
    check(ref_int_sel == 1'b1, "R9 reference kept", ref_int_sel, 1);
    cfg_write(6, 1'b0);
    check(mux_sel == 3'd4, "R9 channel 6 ignored", mux_sel, 4);
    cfg_write(5, 1'b0);
    check(mux_sel == 3'd5 && ref_int_sel == 1'b0, "R9 last channel",
          {mux_sel, ref_int_sel}, 10);

    convert(0, 1'b0);     // R5 zero input
    convert(1023, 1'b0);  // R5 full scale
    convert(512, 1'b0);
    convert(341, 1'b0);   // 0101010101
    convert(682, 1'b0);   // 1010101010
    convert(1, 1'b0);
    convert(1022, 1'b0);
    convert(5000, 1'b0);  // R5 beyond full scale
    convert(700, 1'b1);   // R8/R9 disturbed frame
    convert(255, 1'b0);   // R6 byte boundary
    convert(256, 1'b0);

    repeat (5) @(negedge clk);
    check(done == 1'b1, "R7 done stays while idle", done, 1);
    check(exp_q.size() == 0, "R5 all results seen", exp_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule